// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Estimator

This block forms a coarse reciprocal estimate of a floating-point operand by working only on its exponent. For an ordinary operand the sign passes through, the biased exponent field is replaced by its bitwise complement, and every fraction bit is cleared. An operand whose exponent field is zero (a zero or a subnormal) is given the largest finite exponent instead. An infinity follows the complement rule and so becomes a zero of the same sign. The result is a power of two that a later refinement step can start from.

NaN operands follow a quiet/default policy. A signaling NaN is made quiet and raises an invalid-operation flag. A quiet NaN passes through unchanged. When the default-NaN mode input is set, every NaN is replaced by the canonical quiet NaN of the selected format.

One input selects single or double precision. A single-precision operand sits in the low 32 bits of the 64-bit operand port. Results are registered, so each accepted operand produces one result with a valid strobe one clock later.

Top module: `fp_recip_exp`

## Requirements
- R1: For a non-NaN operand, the result sign equals the operand sign and every result fraction bit is zero (fraction is bits 22:0 for single precision, bits 51:0 for double precision).
- R2: For a non-NaN operand with a nonzero exponent field, the result exponent is the bitwise NOT of the operand exponent. The exponent is bits 30:23 for single precision and bits 62:52 for double precision. An infinity therefore becomes a zero of the same sign.
- R3: For an operand whose exponent field is zero, the result exponent is 0xFE for single precision and 0x7FE for double precision.
- R4: A NaN has an all-ones exponent and a nonzero fraction, and it is quiet when the fraction MSB (bit 22 for single, bit 51 for double) is 1. With default-NaN mode off, a signaling NaN is returned with that bit set, all other bits unchanged, and invalid_flag = 1. A quiet NaN is returned unchanged with invalid_flag = 0.
- R5: With dflt_nan_en = 1, any NaN operand yields 0x7FC00000 (single) or 0x7FF8000000000000 (double). invalid_flag is still 1 for a signaling NaN and 0 for a quiet NaN.
- R6: With dbl_sel = 0 the operand is taken from operand[31:0], operand[63:32] has no effect, and result[63:32] is zero. With dbl_sel = 1 all 64 bits form a double.
- R7: Each cycle with in_valid = 1 produces out_valid = 1 on the next cycle, with result and invalid_flag for that operand. Back-to-back operands are accepted every cycle.
- R8: After a cycle with in_valid = 0, out_valid is 0 and result and invalid_flag keep their previous values.
- R9: While reset is active and after its release, out_valid, result and invalid_flag are 0 until the first operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | Operand; single precision uses bits 31:0 |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| dflt_nan_en | input | 1 | 1 = replace every NaN with the canonical quiet NaN |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Estimated reciprocal exponent value or NaN |
| invalid_flag | output | 1 | Signaling NaN seen for this result |

## Verification
Quieting with the invalid flag and default-NaN substitution can both apply to the same operand: a signaling NaN presented while default-NaN mode is on. The bench drives that case in both precisions. It expects the canonical NaN on result and invalid_flag still set in the same output cycle, so a design that lets one path suppress the other is caught. Back-to-back operands of alternating precision and NaN kind check that the flag and the result stay matched to the correct operand.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int unsigned OP_W      = 64;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int unsigned DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/frx_rst_sync.sv
module frx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/frx_fmt_path.sv
module frx_fmt_path #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  logic                  dnan_i,
  output logic [EXP_W+FRAC_W:0] res_o,
  output logic                  inv_o
);
  localparam int unsigned W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              is_nan;
  logic              is_snan;

  always_comb begin
    sgn     = op_i[W-1];
    ex      = op_i[W-2 -: EXP_W];
    fr      = op_i[FRAC_W-1:0];
    is_nan  = (&ex) && (|fr);
    is_snan = is_nan && !fr[FRAC_W-1];
    inv_o   = is_snan;
    if (is_nan) begin
      res_o = dnan_i ? DNAN : (op_i | QBIT);
    end else if (ex == '0) begin
      res_o = {sgn, EXP_MAXFIN, {FRAC_W{1'b0}}};
    end else begin
      res_o = {sgn, ~ex, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/frx_out_reg.sv
module frx_out_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] res_d_i,
  input  logic         inv_d_i,
  output logic [W-1:0] res_q_o,
  output logic         inv_q_o,
  output logic         vld_q_o
);
  logic [W-1:0] res_q, res_n;
  logic         inv_q, inv_n;
  logic         vld_q, vld_n;

  always_comb begin
    res_n = res_q;
    inv_n = inv_q;
    if (en_i) begin
      res_n = res_d_i;
      inv_n = inv_d_i;
    end
    vld_n = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      inv_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_n;
      inv_q <= inv_n;
      vld_q <= vld_n;
    end
  end

  assign res_q_o = res_q;
  assign inv_q_o = inv_q;
  assign vld_q_o = vld_q;

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> vld_q_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!vld_q_o && $stable(res_q_o) && $stable(inv_q_o)));
endmodule

// File: rtl/fp_recip_exp.sv
module fp_recip_exp
  import frx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic        dbl_sel,
  input  logic        dflt_nan_en,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        invalid_flag
);
  logic            rst_n_s;
  logic [SP_W-1:0] sp_res;
  logic [DP_W-1:0] dp_res;
  logic            sp_inv, dp_inv;
  logic [OP_W-1:0] res_sel;
  logic            inv_sel;

  frx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_fmt
      if (g == 0) begin : g_sp
        frx_fmt_path #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_path (
          .op_i(operand[SP_W-1:0]), .dnan_i(dflt_nan_en),
          .res_o(sp_res), .inv_o(sp_inv)
        );
      end else begin : g_dp
        frx_fmt_path #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_path (
          .op_i(operand[DP_W-1:0]), .dnan_i(dflt_nan_en),
          .res_o(dp_res), .inv_o(dp_inv)
        );
      end
    end
  endgenerate

  always_comb begin
    if (dbl_sel) begin
      res_sel = dp_res;
      inv_sel = dp_inv;
    end else begin
      res_sel = {{(OP_W-SP_W){1'b0}}, sp_res};
      inv_sel = sp_inv;
    end
  end

  frx_out_reg #(.W(OP_W)) u_oreg (
    .clk(clk), .rst_n(rst_n_s), .en_i(in_valid),
    .res_d_i(res_sel), .inv_d_i(inv_sel),
    .res_q_o(result), .inv_q_o(invalid_flag), .vld_q_o(out_valid)
  );

  // R1
  dp_sign_frac_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && dbl_sel && !(&operand[62:52]))
    |=> (result[63] == $past(operand[63]) && result[51:0] == 52'd0));
  // R4
  sp_snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && !dbl_sel && (&operand[30:23]) && (|operand[22:0]) && !operand[22])
    |=> (invalid_flag && result[22]));
  // R5
  dp_dnan_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && dbl_sel && dflt_nan_en && (&operand[62:52]) && (|operand[51:0]))
    |=> (result == 64'h7FF8_0000_0000_0000));
  // R6
  sp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && !dbl_sel) |=> (result[63:32] == 32'd0));
endmodule

// File: tb/sim_fp_recip_exp.sv
module sim_fp_recip_exp;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic        dbl_sel;
  logic        dflt_nan_en;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fp_recip_exp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .dbl_sel(dbl_sel), .dflt_nan_en(dflt_nan_en), .out_valid(out_valid),
    .result(result), .invalid_flag(invalid_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check at following negedge (one register stage)
  task automatic run_op(input string tag, input logic [63:0] op, input logic dbl,
                        input logic dn, input logic [63:0] exp_res, input logic exp_inv);
    @(negedge clk);
    in_valid = 1'b1; operand = op; dbl_sel = dbl; dflt_nan_en = dn;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " result"}, result, exp_res);
    chk({tag, " invalid"}, {63'd0, invalid_flag}, {63'd0, exp_inv});
  endtask

  task automatic t_reset();
    chk("R9 valid", {63'd0, out_valid}, 64'd0);
    chk("R9 result", result, 64'd0);
    chk("R9 invalid", {63'd0, invalid_flag}, 64'd0);
  endtask

  task automatic t_normal();
    run_op("R2 sp 1.0", 64'h0000_0000_3F80_0000, 1'b0, 1'b0, 64'h0000_0000_4000_0000, 1'b0);
    run_op("R1 sp -2.5", 64'h0000_0000_C020_0000, 1'b0, 1'b0, 64'h0000_0000_BF80_0000, 1'b0);
    run_op("R2 dp 1.0", 64'h3FF0_0000_0000_0000, 1'b1, 1'b0, 64'h4000_0000_0000_0000, 1'b0);
    run_op("R1 dp -0.5 frac", 64'hBFE1_2345_6789_ABCD, 1'b1, 1'b0, 64'hC010_0000_0000_0000, 1'b0);
    run_op("R2 sp +inf", 64'h0000_0000_7F80_0000, 1'b0, 1'b0, 64'h0, 1'b0);
    run_op("R2 dp -inf", 64'hFFF0_0000_0000_0000, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 1'b0);
  endtask

  task automatic t_zero_exp();
    run_op("R3 sp zero", 64'h0, 1'b0, 1'b0, 64'h0000_0000_7F00_0000, 1'b0);
    run_op("R3 sp neg subnormal", 64'h0000_0000_8000_0001, 1'b0, 1'b0, 64'h0000_0000_FF00_0000, 1'b0);
    run_op("R3 dp zero", 64'h0, 1'b1, 1'b0, 64'h7FE0_0000_0000_0000, 1'b0);
    run_op("R3 dp neg subnormal", 64'h8000_0000_0000_0001, 1'b1, 1'b0, 64'hFFE0_0000_0000_0000, 1'b0);
  endtask

  task automatic t_nan();
    run_op("R4 sp snan", 64'h0000_0000_7F80_0001, 1'b0, 1'b0, 64'h0000_0000_7FC0_0001, 1'b1);
    run_op("R4 sp qnan", 64'h0000_0000_FFC0_0123, 1'b0, 1'b0, 64'h0000_0000_FFC0_0123, 1'b0);
    run_op("R4 dp snan", 64'hFFF0_0000_0000_0001, 1'b1, 1'b0, 64'hFFF8_0000_0000_0001, 1'b1);
    run_op("R5 sp snan dnan", 64'h0000_0000_FF80_0005, 1'b0, 1'b1, 64'h0000_0000_7FC0_0000, 1'b1);
    run_op("R5 sp qnan dnan", 64'h0000_0000_FFC0_0001, 1'b0, 1'b1, 64'h0000_0000_7FC0_0000, 1'b0);
    run_op("R5 dp snan dnan", 64'hFFF4_0000_0000_0000, 1'b1, 1'b1, 64'h7FF8_0000_0000_0000, 1'b1);
    run_op("R5 dnan no effect on normal", 64'h0000_0000_3F80_0000, 1'b0, 1'b1, 64'h0000_0000_4000_0000, 1'b0);
  endtask

  task automatic t_precision();
    run_op("R6 sp upper ignored", 64'hDEAD_BEEF_3F80_0000, 1'b0, 1'b0, 64'h0000_0000_4000_0000, 1'b0);
    run_op("R6 sp upper nan-like", 64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 64'h0000_0000_7F00_0000, 1'b0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    in_valid = 1'b1; operand = 64'hFFF0_0000_0000_0001; dbl_sel = 1'b1; dflt_nan_en = 1'b0;
    @(negedge clk);
    chk("R7 b2b first result", result, 64'hFFF8_0000_0000_0001);
    chk("R7 b2b first invalid", {63'd0, invalid_flag}, 64'd1);
    operand = 64'h0000_0000_3F80_0000; dbl_sel = 1'b0;
    @(negedge clk);
    chk("R7 b2b second valid", {63'd0, out_valid}, 64'd1);
    chk("R7 b2b second result", result, 64'h0000_0000_4000_0000);
    chk("R7 b2b second invalid", {63'd0, invalid_flag}, 64'd0);
    in_valid = 1'b0;
  endtask

  task automatic t_idle_hold();
    run_op("R8 setup", 64'h0000_0000_7F80_0001, 1'b0, 1'b0, 64'h0000_0000_7FC0_0001, 1'b1);
    operand = 64'h3FF0_0000_0000_0000; dbl_sel = 1'b1;
    @(negedge clk);
    chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R8 idle result held", result, 64'h0000_0000_7FC0_0001);
    chk("R8 idle invalid held", {63'd0, invalid_flag}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; dbl_sel = 1'b0; dflt_nan_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_zero_exp();
    t_nan();
    t_precision();
    t_back_to_back();
    t_idle_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule